// File: doc/BRIEF.md
# IEEE 488 Device Talker/Listener Interface

This block connects a small microprocessor to an IEEE 488 instrument bus as a device that can talk and listen but cannot act as system controller. The processor reaches it through eight byte-wide register offsets. Each offset holds one register for reads and a different register for writes. The processor loads a five-bit bus address. The block then watches command bytes sent with ATN asserted, enters the listener or talker addressed state when its own address appears, and runs the three-wire byte handshake for data moving in either direction.

Eleven event sources set sticky bits in a sixteen-bit status pair. Reading a status byte clears that byte. A mask pair selects which bits pull the active-low interrupt output. The talk-enable output sets the direction of the external transceivers. The controller-direction output is held at its inactive high level.

All bus signals on the ports are active high, meaning "asserted". A value of 1 corresponds to the electrically low line on the real bus. A "_out" line at 1 means the block is pulling that line.

Top module: `gpib_dev_if`

## Requirements
- R1: An access happens only while cs_n is low. rd_wn=1 reads and rd_wn=0 writes. The write offsets are: 0 mask bits 7:0, 1 mask bits 15:8, 4 bus address (bits 4:0), 5 serial-poll byte, 7 data-out byte. Writes to offsets 2, 3 and 6 are ignored; offset 6 is the unused parallel-poll slot. The read offsets are: 0 status bits 7:0, 1 status bits 15:8, 2 state byte {5'b0, remote, talker, listener}, 7 data-in byte. All other read offsets return 0.
- R2: While cs_n is high, writes have no effect and rdata is 0.
- R3: A command byte whose bits 6:5 are 01 and whose bits 4:0 equal the stored address (which must not be 31) sets listener, clears talker, and sets status bit 4 (addressed). The byte 0x3F clears listener.
- R4: A command byte whose bits 6:5 are 10 and whose bits 4:0 equal the address sets talker, clears listener, and sets status bit 4. If the data-out register is empty at that point, it also sets status bit 1 (ready for output). Any other talk byte, including 0x5F, clears talker.
- R5: talk_en equals the talker state, and ctrl_n is always 1.
- R6: As a listener with ATN deasserted, the block takes a byte on DAV. It releases NDAC until DAV falls, stores the byte in data-in, and sets status bit 0. It also sets status bit 2 if EOI was asserted with that byte. NRFD then stays asserted until data-in is read.
- R7: As a talker with ATN deasserted and a data-out byte pending, the block waits for NRFD to be released. It then drives the byte and asserts DAV. It keeps DAV asserted until NDAC is released. After DAV drops, the data-out register is marked empty and status bit 1 is set.
- R8: Status bits are sticky until their byte is read. irq_n is low exactly when some status bit and its mask bit are both 1.
- R9: IFC clears listener, talker and serial-poll mode and aborts both handshakes. The rising edge of IFC sets status bit 3.
- R10: The command 0x08 (trigger) sets status bit 5 only while the block is a listener. The command 0x04 while the block is a listener, and the command 0x14 in any state, set status bit 6 (device clear).
- R11: Commands 0x10 to 0x1F other than 0x14, 0x18 and 0x19 set status bit 9. While the block is a listener, commands 0x00 to 0x0F other than 0x01, 0x04 and 0x08 set status bit 10. When the block is not a listener, those commands are ignored.
- R12: After command 0x18 and until command 0x19, the talker sends the serial-poll byte in place of data-out. When such a transfer completes with bit 7 of that byte set, status bit 7 is set.
- R13: A matching listen address received while REN is asserted sets remote. Remote is cleared when REN is deasserted, or by command 0x01 while the block is a listener. Every change of remote sets status bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low register chip select |
| rd_wn | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Active-low interrupt |
| bus_atn | input | 1 | ATN asserted |
| bus_eoi | input | 1 | EOI asserted |
| bus_ifc | input | 1 | IFC asserted |
| bus_ren | input | 1 | REN asserted |
| bus_dav_in | input | 1 | DAV asserted by another device |
| bus_nrfd_in | input | 1 | NRFD asserted by listeners |
| bus_ndac_in | input | 1 | NDAC asserted by listeners |
| bus_dio_in | input | 8 | Data lines received |
| bus_dav_out | output | 1 | Block asserts DAV |
| bus_nrfd_out | output | 1 | Block asserts NRFD |
| bus_ndac_out | output | 1 | Block asserts NDAC |
| bus_dio_out | output | 8 | Data lines driven while DAV is asserted |
| talk_en | output | 1 | Transceiver direction, high while talker |
| ctrl_n | output | 1 | Controller direction, held high |

## Verification
Any wrong addressed state shows up one clock after the command handshake. It appears on talk_en and on the state byte at offset 2. It also shows in whether NDAC is pulled when ATN drops. A lost or stuck status bit appears on irq_n in the cycle after the event, and in the status byte on the next read. A handshake fault shows up as DAV rising before NRFD is released, as DAV being held past NDAC, as NRFD not being held while data-in is unread, or as the wrong byte on the data lines. Each such fault appears within one or two clocks of the bus edge that should have caused it.

// File: rtl/gpib_pkg.sv
package gpib_pkg;
    localparam int DW     = 8;
    localparam int SEL_W  = 3;
    localparam int ADR_W  = 5;
    localparam int STAT_W = 16;

    localparam logic [SEL_W-1:0] O_LO    = 3'd0;
    localparam logic [SEL_W-1:0] O_HI    = 3'd1;
    localparam logic [SEL_W-1:0] O_STATE = 3'd2;
    localparam logic [SEL_W-1:0] O_ADDR  = 3'd4;
    localparam logic [SEL_W-1:0] O_POLL  = 3'd5;
    localparam logic [SEL_W-1:0] O_DATA  = 3'd7;

    localparam int E_BI   = 0;
    localparam int E_BO   = 1;
    localparam int E_END  = 2;
    localparam int E_IFC  = 3;
    localparam int E_MA   = 4;
    localparam int E_TRG  = 5;
    localparam int E_DCL  = 6;
    localparam int E_POLL = 7;
    localparam int E_RLC  = 8;
    localparam int E_UUC  = 9;
    localparam int E_UAC  = 10;

    typedef enum logic {AH_READY, AH_ACCEPT} ah_state_e;
    typedef enum logic {SH_IDLE, SH_DRIVE} sh_state_e;

    typedef struct packed {
        logic [ADR_W-1:0]  my_addr;
        logic [STAT_W-1:0] imr;
        logic [STAT_W-1:0] isr;
        logic [DW-1:0]     spoll;
        logic [DW-1:0]     dout;
        logic [DW-1:0]     din;
        logic              do_full;
        logic              di_full;
        logic              lad;
        logic              tad;
        logic              spe;
        logic              rem;
        logic              ifc_prev;
    } dev_regs_t;
endpackage

// File: rtl/gpib_acceptor.sv
module gpib_acceptor
    import gpib_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          engaged,
    input  logic          hold,
    input  logic          dav_in,
    input  logic          atn_in,
    input  logic          eoi_in,
    input  logic [DW-1:0] dio_in,
    output logic          nrfd_out,
    output logic          ndac_out,
    output logic          take,
    output logic          is_cmd,
    output logic          is_end,
    output logic [DW-1:0] rx_byte
);
    typedef struct packed {
        ah_state_e     st;
        logic          take;
        logic          cmd;
        logic          eom;
        logic [DW-1:0] data;
    } ah_t;

    ah_t ah_d, ah_q;

    always_comb begin
        ah_d = ah_q;
        ah_d.take = 1'b0;
        case (ah_q.st)
            AH_READY: if (engaged && !hold && dav_in) begin
                ah_d.st   = AH_ACCEPT;
                ah_d.take = 1'b1;
                ah_d.cmd  = atn_in;
                ah_d.eom  = eoi_in;
                ah_d.data = dio_in;
            end
            AH_ACCEPT: if (!dav_in) ah_d.st = AH_READY;
            default: ah_d.st = AH_READY;
        endcase
        if (clear) begin
            ah_d.st   = AH_READY;
            ah_d.take = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ah_q <= '{st: AH_READY, take: 1'b0, cmd: 1'b0, eom: 1'b0, data: '0};
        else        ah_q <= ah_d;
    end

    assign nrfd_out = (ah_q.st == AH_ACCEPT) || (engaged && hold);
    assign ndac_out = (ah_q.st == AH_READY) && engaged;
    assign take     = ah_q.take;
    assign is_cmd   = ah_q.cmd;
    assign is_end   = ah_q.eom;
    assign rx_byte  = ah_q.data;

    // R6: a byte is only taken after DAV was seen asserted
    a_r6_take_needs_dav: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(dav_in));
    // R6: once taken, NRFD is held while DAV is still asserted
    a_r6_nrfd_during_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dav_in && !clear) |-> nrfd_out);
endmodule

// File: rtl/gpib_source.sv
module gpib_source
    import gpib_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          go,
    input  logic [DW-1:0] tx_byte,
    input  logic          nrfd_in,
    input  logic          ndac_in,
    output logic          dav_out,
    output logic [DW-1:0] dio_out,
    output logic          done
);
    typedef struct packed {
        sh_state_e     st;
        logic          done;
        logic [DW-1:0] data;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        sh_d.done = 1'b0;
        case (sh_q.st)
            SH_IDLE: if (go && !nrfd_in) begin
                sh_d.st   = SH_DRIVE;
                sh_d.data = tx_byte;
            end
            SH_DRIVE: if (!ndac_in) begin
                sh_d.st   = SH_IDLE;
                sh_d.done = 1'b1;
            end
            default: sh_d.st = SH_IDLE;
        endcase
        if (clear) begin
            sh_d.st   = SH_IDLE;
            sh_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{st: SH_IDLE, done: 1'b0, data: '0};
        else        sh_q <= sh_d;
    end

    assign dav_out = (sh_q.st == SH_DRIVE);
    assign dio_out = dav_out ? sh_q.data : '0;
    assign done    = sh_q.done;

    // R7: DAV only rises after NRFD was seen released
    a_r7_dav_after_nrfd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_out) |-> $past(!nrfd_in));
    // R7: DAV only falls when NDAC was released or the handshake was aborted
    a_r7_dav_drop_on_ndac: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_out) |-> $past(!ndac_in || clear));
    // R7: the bus byte stays put while DAV is asserted
    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_out && $past(dav_out)) |-> $stable(dio_out));
endmodule

// File: rtl/gpib_dev_if.sv
module gpib_dev_if
    import gpib_pkg::*;
#(
    parameter logic [ADR_W-1:0] RESET_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_wn,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_n,
    input  logic             bus_atn,
    input  logic             bus_eoi,
    input  logic             bus_ifc,
    input  logic             bus_ren,
    input  logic             bus_dav_in,
    input  logic             bus_nrfd_in,
    input  logic             bus_ndac_in,
    input  logic [DW-1:0]    bus_dio_in,
    output logic             bus_dav_out,
    output logic             bus_nrfd_out,
    output logic             bus_ndac_out,
    output logic [DW-1:0]    bus_dio_out,
    output logic             talk_en,
    output logic             ctrl_n
);
    localparam int HALF = STAT_W / 2;

    dev_regs_t d, q;
    logic [STAT_W-1:0] set_ev, clr_ev;
    logic              rd_en, wr_en;
    logic [6:0]        cb;
    logic              rx_take, rx_cmd, rx_end, tx_done, tx_go;
    logic [DW-1:0]     rx_byte, tx_byte;

    gpib_acceptor u_acc (
        .clk(clk), .rst_n(rst_n), .clear(bus_ifc),
        .engaged(bus_atn || q.lad), .hold(q.di_full && !bus_atn),
        .dav_in(bus_dav_in), .atn_in(bus_atn), .eoi_in(bus_eoi), .dio_in(bus_dio_in),
        .nrfd_out(bus_nrfd_out), .ndac_out(bus_ndac_out),
        .take(rx_take), .is_cmd(rx_cmd), .is_end(rx_end), .rx_byte(rx_byte)
    );

    assign tx_byte = q.spe ? q.spoll : q.dout;
    assign tx_go   = q.tad && !bus_atn && !tx_done && (q.spe || q.do_full);

    gpib_source u_src (
        .clk(clk), .rst_n(rst_n), .clear(bus_ifc || bus_atn),
        .go(tx_go), .tx_byte(tx_byte),
        .nrfd_in(bus_nrfd_in), .ndac_in(bus_ndac_in),
        .dav_out(bus_dav_out), .dio_out(bus_dio_out), .done(tx_done)
    );

    always_comb begin
        d      = q;
        set_ev = '0;
        clr_ev = '0;
        cb     = rx_byte[6:0];
        rd_en  = !cs_n && rd_wn;
        wr_en  = !cs_n && !rd_wn;

        if (wr_en) begin
            case (reg_sel)
                O_LO:    d.imr[HALF-1:0]      = wdata;
                O_HI:    d.imr[STAT_W-1:HALF] = wdata;
                O_ADDR:  d.my_addr            = wdata[ADR_W-1:0];
                O_POLL:  d.spoll              = wdata;
                O_DATA:  begin d.dout = wdata; d.do_full = 1'b1; end
                default: ;
            endcase
        end
        if (rd_en) begin
            case (reg_sel)
                O_LO:    clr_ev[HALF-1:0]      = '1;
                O_HI:    clr_ev[STAT_W-1:HALF] = '1;
                O_DATA:  d.di_full             = 1'b0;
                default: ;
            endcase
        end

        if (rx_take && rx_cmd) begin
            if (cb[6:5] == 2'b01) begin
                if (cb[4:0] == 5'h1F) d.lad = 1'b0;
                else if (cb[4:0] == q.my_addr) begin
                    d.lad = 1'b1;
                    d.tad = 1'b0;
                    set_ev[E_MA] = 1'b1;
                    if (bus_ren) d.rem = 1'b1;
                end
            end else if (cb[6:5] == 2'b10) begin
                if (cb[4:0] != 5'h1F && cb[4:0] == q.my_addr) begin
                    d.tad = 1'b1;
                    d.lad = 1'b0;
                    set_ev[E_MA] = 1'b1;
                    if (!q.do_full) set_ev[E_BO] = 1'b1;
                end else d.tad = 1'b0;
            end else if (cb[6:4] == 3'b001) begin
                case (cb[3:0])
                    4'h4:    set_ev[E_DCL] = 1'b1;
                    4'h8:    d.spe = 1'b1;
                    4'h9:    d.spe = 1'b0;
                    default: set_ev[E_UUC] = 1'b1;
                endcase
            end else if (cb[6:4] == 3'b000 && q.lad) begin
                case (cb[3:0])
                    4'h1:    d.rem = 1'b0;
                    4'h4:    set_ev[E_DCL] = 1'b1;
                    4'h8:    set_ev[E_TRG] = 1'b1;
                    default: set_ev[E_UAC] = 1'b1;
                endcase
            end
        end else if (rx_take && q.lad) begin
            d.din        = rx_byte;
            d.di_full    = 1'b1;
            set_ev[E_BI] = 1'b1;
            if (rx_end) set_ev[E_END] = 1'b1;
        end

        if (tx_done) begin
            if (q.spe) begin
                if (q.spoll[DW-1]) set_ev[E_POLL] = 1'b1;
            end else begin
                d.do_full    = 1'b0;
                set_ev[E_BO] = 1'b1;
            end
        end

        if (!bus_ren) d.rem = 1'b0;
        if (bus_ifc) begin
            d.lad     = 1'b0;
            d.tad     = 1'b0;
            d.spe     = 1'b0;
            d.di_full = 1'b0;
            d.do_full = 1'b0;
            if (!q.ifc_prev) set_ev[E_IFC] = 1'b1;
        end
        if (d.rem != q.rem) set_ev[E_RLC] = 1'b1;
        d.ifc_prev = bus_ifc;
        d.isr      = (q.isr & ~clr_ev) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.my_addr <= RESET_ADDR;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel)
                O_LO:    rdata = q.isr[HALF-1:0];
                O_HI:    rdata = q.isr[STAT_W-1:HALF];
                O_STATE: rdata = {5'b0, q.rem, q.tad, q.lad};
                O_DATA:  rdata = q.din;
                default: rdata = '0;
            endcase
        end
    end

    assign irq_n   = ~|(q.isr & q.imr);
    assign talk_en = q.tad;
    assign ctrl_n  = 1'b1;

    // R3/R4: talker and listener never held together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.tad && q.lad));
    // R9: IFC leaves the interface unaddressed on the next cycle
    a_r9_ifc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ifc |=> (!talk_en && !q.lad && !bus_dav_out));
    // R8: a status byte read with no new event leaves that byte clear
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == O_LO && set_ev[HALF-1:0] == '0) |=> (q.isr[HALF-1:0] == '0));
    // R13: remote never survives a deasserted REN
    a_r13_ren_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> !q.rem);
endmodule

// File: tb/gpib_dev_if_bench.sv
module gpib_dev_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_wn = 1'b1;
    logic [2:0] reg_sel = '0;
    logic [7:0] wdata = '0, rdata;
    logic       irq_n;
    logic       atn = 1'b0, eoi = 1'b0, ifc = 1'b0, ren = 1'b0;
    logic       dav_i = 1'b0, nrfd_i = 1'b1, ndac_i = 1'b1;
    logic [7:0] dio_i = '0, dio_o;
    logic       dav_o, nrfd_o, ndac_o, talk_en, ctrl_n;
    int         checks = 0, errors = 0;
    bit         ended = 1'b0;

    always #4 clk = ~clk;

    gpib_dev_if u_gpib_dev_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wn(rd_wn), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
        .bus_atn(atn), .bus_eoi(eoi), .bus_ifc(ifc), .bus_ren(ren),
        .bus_dav_in(dav_i), .bus_nrfd_in(nrfd_i), .bus_ndac_in(ndac_i), .bus_dio_in(dio_i),
        .bus_dav_out(dav_o), .bus_nrfd_out(nrfd_o), .bus_ndac_out(ndac_o),
        .bus_dio_out(dio_o), .talk_en(talk_en), .ctrl_n(ctrl_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rd_wn = 1'b0; reg_sel = s; wdata = v;
        @(negedge clk); cs_n = 1'b1; rd_wn = 1'b1;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rd_wn = 1'b1; reg_sel = s;
        #1 v = rdata;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] s, input logic [7:0] exp);
        logic [7:0] v;
        rd(s, v);
        chk(tag, {8'h0, v}, {8'h0, exp});
    endtask

    task automatic clr_stat();
        logic [7:0] v;
        rd(3'd0, v);
        rd(3'd1, v);
    endtask

    // controller side of the handshake: one byte into the block
    task automatic send(input logic [7:0] b, input logic a, input logic e);
        int n;
        @(negedge clk); atn = a; eoi = e; dio_i = b;
        n = 0;
        while (nrfd_o && n < 20) begin @(negedge clk); n++; end
        if (n >= 20) begin checks++; errors++; $display("FAIL R6: actual=nrfd_held expected=released"); end
        dav_i = 1'b1;
        n = 0;
        while (ndac_o && n < 20) begin @(negedge clk); n++; end
        if (n >= 20) begin checks++; errors++; $display("FAIL R6: actual=ndac_held expected=released"); end
        @(negedge clk); dav_i = 1'b0; eoi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R5 reset talk_en", {15'h0, talk_en}, 16'h0);
        chk("R5 reset ctrl_n", {15'h0, ctrl_n}, 16'h1);
        chk("R8 reset irq_n", {15'h0, irq_n}, 16'h1);
        chk("R7 reset dav", {15'h0, dav_o}, 16'h0);
        chk("R6 reset nrfd/ndac", {14'h0, nrfd_o, ndac_o}, 16'h0);
        rd_chk("R1 reset state", 3'd2, 8'h00);
    endtask

    task automatic t_regmap();
        wr(3'd0, 8'hA5);
        rd_chk("R1 offset0 read is status not mask", 3'd0, 8'h00);
        wr(3'd6, 8'hFF);
        rd_chk("R1 parallel poll slot reads 0", 3'd6, 8'h00);
        rd_chk("R1 address is write only", 3'd4, 8'h00);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_listen();
        wr(3'd4, 8'h09);
        @(negedge clk); cs_n = 1'b1; rd_wn = 1'b0; reg_sel = 3'd4; wdata = 8'h03;
        @(negedge clk);
        chk("R2 rdata 0 without select", {8'h0, rdata}, 16'h0);
        rd_wn = 1'b1;
        wr(3'd0, 8'h10);
        send(8'h23, 1'b1, 1'b0);
        rd_chk("R2 unselected address write ignored", 3'd2, 8'h00);
        send(8'h29, 1'b1, 1'b0);
        chk("R8 irq low on masked event", {15'h0, irq_n}, 16'h0);
        rd_chk("R3 listener state", 3'd2, 8'h01);
        rd_chk("R3 addressed status bit", 3'd0, 8'h10);
        chk("R8 irq released after read", {15'h0, irq_n}, 16'h1);
        rd_chk("R8 status cleared", 3'd0, 8'h00);
        wr(3'd0, 8'h00);
        send(8'h3F, 1'b1, 1'b0);
        rd_chk("R3 unlisten", 3'd2, 8'h00);
    endtask

    task automatic t_receive();
        send(8'h29, 1'b1, 1'b0);
        clr_stat();
        send(8'h5A, 1'b0, 1'b1);
        chk("R6 nrfd held while unread", {15'h0, nrfd_o}, 16'h1);
        rd_chk("R6 byte-in and end status", 3'd0, 8'h05);
        rd_chk("R6 data-in byte", 3'd7, 8'h5A);
        chk("R6 nrfd released after read", {15'h0, nrfd_o}, 16'h0);
        chk("R6 ndac asserted when ready", {15'h0, ndac_o}, 16'h1);
        send(8'h33, 1'b0, 1'b0);
        rd_chk("R6 no end without EOI", 3'd0, 8'h01);
        rd_chk("R6 second byte", 3'd7, 8'h33);
        send(8'h3F, 1'b1, 1'b0);
        @(negedge clk); atn = 1'b0;
    endtask

    task automatic t_talk();
        clr_stat();
        send(8'h49, 1'b1, 1'b0);
        rd_chk("R4 talker state", 3'd2, 8'h02);
        chk("R5 talk_en high", {15'h0, talk_en}, 16'h1);
        chk("R5 ctrl_n high", {15'h0, ctrl_n}, 16'h1);
        rd_chk("R4 addressed plus ready status", 3'd0, 8'h12);
        wr(3'd7, 8'hC3);
        @(negedge clk); atn = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 waits while nrfd asserted", {15'h0, dav_o}, 16'h0);
        nrfd_i = 1'b0;
        @(negedge clk);
        chk("R7 dav after nrfd release", {15'h0, dav_o}, 16'h1);
        chk("R7 byte on bus", {8'h0, dio_o}, 16'h00C3);
        repeat (3) @(negedge clk);
        chk("R7 dav held while ndac asserted", {15'h0, dav_o}, 16'h1);
        ndac_i = 1'b0; nrfd_i = 1'b1;
        @(negedge clk);
        chk("R7 dav drops on ndac release", {15'h0, dav_o}, 16'h0);
        repeat (2) @(negedge clk);
        ndac_i = 1'b1;
        rd_chk("R7 ready-for-output after transfer", 3'd0, 8'h02);
        send(8'h45, 1'b1, 1'b0);
        rd_chk("R4 other talk address clears talker", 3'd2, 8'h00);
        chk("R5 talk_en low", {15'h0, talk_en}, 16'h0);
    endtask

    task automatic t_events();
        clr_stat();
        send(8'h08, 1'b1, 1'b0);
        rd_chk("R10 trigger ignored when not listener", 3'd0, 8'h00);
        send(8'h29, 1'b1, 1'b0);
        clr_stat();
        send(8'h08, 1'b1, 1'b0);
        rd_chk("R10 trigger as listener", 3'd0, 8'h20);
        send(8'h04, 1'b1, 1'b0);
        rd_chk("R10 selected clear", 3'd0, 8'h40);
        send(8'h05, 1'b1, 1'b0);
        rd_chk("R11 unknown addressed cmd", 3'd1, 8'h04);
        send(8'h3F, 1'b1, 1'b0);
        send(8'h14, 1'b1, 1'b0);
        rd_chk("R10 universal clear", 3'd0, 8'h40);
        send(8'h11, 1'b1, 1'b0);
        rd_chk("R11 unknown universal cmd", 3'd1, 8'h02);
        send(8'h05, 1'b1, 1'b0);
        rd_chk("R11 addressed cmd ignored when not listener", 3'd1, 8'h00);
    endtask

    task automatic t_spoll();
        int n;
        wr(3'd5, 8'hC1);
        send(8'h49, 1'b1, 1'b0);
        send(8'h18, 1'b1, 1'b0);
        clr_stat();
        @(negedge clk); atn = 1'b0; nrfd_i = 1'b0;
        n = 0;
        while (!dav_o && n < 10) begin @(negedge clk); n++; end
        chk("R12 serial poll byte on bus", {7'h0, dav_o, dio_o}, 16'h01C1);
        nrfd_i = 1'b1; ndac_i = 1'b0;
        repeat (3) @(negedge clk);
        ndac_i = 1'b1;
        rd_chk("R12 poll status bit", 3'd0, 8'h80);
        send(8'h19, 1'b1, 1'b0);
        send(8'h5F, 1'b1, 1'b0);
        rd_chk("R4 untalk", 3'd2, 8'h00);
    endtask

    task automatic t_remote();
        clr_stat();
        @(negedge clk); ren = 1'b1;
        send(8'h29, 1'b1, 1'b0);
        rd_chk("R13 remote set", 3'd2, 8'h05);
        rd_chk("R13 change status", 3'd1, 8'h01);
        @(negedge clk); ren = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R13 local on ren drop", 3'd2, 8'h01);
        rd_chk("R13 change status on drop", 3'd1, 8'h01);
        @(negedge clk); ren = 1'b1;
        send(8'h29, 1'b1, 1'b0);
        clr_stat();
        send(8'h01, 1'b1, 1'b0);
        rd_chk("R13 go-to-local", 3'd2, 8'h01);
        rd_chk("R13 change status on go-to-local", 3'd1, 8'h01);
        @(negedge clk); ren = 1'b0;
    endtask

    task automatic t_ifc();
        @(negedge clk); atn = 1'b0;
        clr_stat();
        chk("R6 listener holds ndac", {15'h0, ndac_o}, 16'h1);
        @(negedge clk); ifc = 1'b1;
        repeat (3) @(negedge clk);
        ifc = 1'b0;
        @(negedge clk);
        rd_chk("R9 idle after ifc", 3'd2, 8'h00);
        rd_chk("R9 ifc status once", 3'd0, 8'h08);
        chk("R9 handshake lines released", {14'h0, nrfd_o, ndac_o}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_listen();
        t_receive();
        t_talk();
        t_events();
        t_spoll();
        t_remote();
        t_ifc();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule